// File: doc/BRIEF.md
# Reference Link Cell Rate Integrator

This block recovers the received data cell rate of each link group in an inverse-multiplexed ATM receiver. Each group picks one of its member links as its reference. The block counts the cell arrivals on that link over an integration window, which is measured in ticks of a local timebase. When a window closes, the block latches the count into a per-group result and raises a one-cycle done strobe. The window counter then starts again from zero.

The reference link comes from one of two sources. Software can set it in a per-group control word. Or, in automatic mode, the block takes it from the link field of the most recent valid control cell received on a member link of that group. A new reference is applied only at a window boundary. A latched count therefore never mixes cells from two links.

Top module: `ref_rate_integrator`

## Requirements
- R1: After reset, every group has a rate of 0, done low, link 0 as its active reference and a stored automatic link of 0.
- R2: Each group has its own tick counter. A window boundary occurs in the cycle that carries the P-th `tick_i` since the previous boundary or since reset, where P is the group's period field. A period value of 0 acts as 1.
- R3: At a boundary, the group's rate takes the number of arrivals on its active link over the whole window, including the boundary cycle. The new rate is visible in the cycle after the boundary. The accumulation restarts from zero.
- R4: The group's `done_o` bit is high for exactly the cycle after each boundary cycle. At all other times it is low and the rate holds its value.
- R5: The accumulated count saturates at 2^CNT_W-1 (65535 by default) and does not wrap.
- R6: When bit 4 of the group's control word is 0, bits [1:0] select the reference link. The selection held in the boundary cycle becomes the active link from the following cycle. Changes made between boundaries have no effect on the count in progress.
- R7: A valid control-cell strobe on link L updates group g's stored automatic link to that link's 2-bit field, but only when link L's group field equals g. If several such strobes arrive in one cycle, the lowest-numbered link wins. Strobes on links of other groups leave group g unchanged.
- R8: When bit 4 of the control word is 1, the stored automatic link, as held before the boundary cycle's own update, becomes the active link at the boundary. A control cell that arrives in the boundary cycle takes effect at the following boundary.
- R9: Arrivals on links other than the group's active link do not change its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Local timebase tick, one cycle per tick |
| cell_arr_i | input | 4 | Per-link cell arrival strobe |
| icp_vld_i | input | 4 | Per-link valid control-cell strobe |
| icp_ref_i | input | 8 | Per-link 2-bit reference-link field of the control cell, link L at [2L+1:2L] |
| link_grp_i | input | 4 | Per-link group membership, link L at bit L |
| ref_ctl_i | input | 10 | Per-group 5-bit control word, group g at [5g+4:5g]; bits [1:0] hold the manual link, bit 4 enables automatic mode |
| period_i | input | 40 | Per-group 20-bit window length in ticks |
| rate_o | output | 32 | Per-group 16-bit latched count |
| done_o | output | 2 | Per-group strobe: a new rate has been latched |

## Verification
The first patterns use dense ticks and random arrivals on every link, with a fixed manual reference. These show whether the boundary lands on the right tick and whether arrivals on the non-reference links are kept out of the count. Sparse, irregular ticks then separate tick counting from cycle counting, and a period of zero tests the every-tick case. Manual link changes in the middle of a window, and bursts of control cells (including simultaneous ones, cells on foreign-group links and cells in the boundary cycle), show whether the reference changes only at the boundary and with the correct priority. A long window with arrivals in every cycle exposes wrap versus saturation.

// File: rtl/rli_pkg.sv
package rli_pkg;

   // how a group chooses its reference link
   typedef enum logic {
      SEL_MANUAL = 1'b0,
      SEL_AUTO   = 1'b1
   } ref_sel_e;

   // width of an index able to address n items (at least 1 bit)
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rli_tick_timer.sv
module rli_tick_timer #(
   parameter int PERIOD_W = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_i,
   input  logic [PERIOD_W-1:0] period_i,
   output logic                bnd_o
);
   localparam int CW = PERIOD_W + 1;

   if (PERIOD_W < 2) begin : g_bad_pw
      $error("rli_tick_timer: PERIOD_W must be at least 2");
   end

   logic [PERIOD_W-1:0] cnt_q;
   logic [CW-1:0]       limit;
   logic [CW-1:0]       nxt;

   assign limit = (period_i == '0) ? CW'(1) : {1'b0, period_i};
   assign nxt   = {1'b0, cnt_q} + CW'(1);
   assign bnd_o = tick_i && (nxt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (bnd_o)  cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + PERIOD_W'(1);
   end

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> $stable(cnt_q));

   // R2
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_o |=> (cnt_q == '0));

endmodule

// File: rtl/rli_ref_track.sv
module rli_ref_track #(
   parameter int NUM_LINKS = 4,
   parameter int LINK_W    = 2,
   parameter int GRP_W     = 1,
   parameter int CTL_W     = 5,
   parameter int AUTO_BIT  = 4,
   parameter int GRP_ID    = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_LINKS-1:0]      icp_vld_i,
   input  logic [NUM_LINKS*LINK_W-1:0] icp_ref_i,
   input  logic [NUM_LINKS*GRP_W-1:0]  link_grp_i,
   input  logic [CTL_W-1:0]          ctl_i,
   input  logic                      bnd_i,
   output logic [LINK_W-1:0]         act_ref_o
);
   import rli_pkg::*;

   if (AUTO_BIT < LINK_W || AUTO_BIT >= CTL_W) begin : g_bad_ctl
      $error("rli_ref_track: AUTO_BIT must lie above the link field inside CTL_W");
   end

   logic [LINK_W-1:0] auto_q;
   logic [LINK_W-1:0] act_q;
   logic [LINK_W-1:0] hit_ref;
   logic [LINK_W-1:0] next_ref;
   logic              hit;
   ref_sel_e          mode;
   logic              ctl_unused;

   assign ctl_unused = ^ctl_i;
   assign mode = ref_sel_e'(ctl_i[AUTO_BIT]);

   // lowest-numbered member link wins: scan downward, last hit kept
   always_comb begin
      hit     = 1'b0;
      hit_ref = '0;
      for (int l = NUM_LINKS - 1; l >= 0; l--) begin
         if (icp_vld_i[l] && (link_grp_i[l*GRP_W +: GRP_W] == GRP_W'(GRP_ID))) begin
            hit     = 1'b1;
            hit_ref = icp_ref_i[l*LINK_W +: LINK_W];
         end
      end
   end

   assign next_ref = (mode == SEL_AUTO) ? auto_q : ctl_i[LINK_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         auto_q <= '0;
         act_q  <= '0;
      end else begin
         if (hit)   auto_q <= hit_ref;
         if (bnd_i) act_q  <= next_ref;
      end
   end

   assign act_ref_o = act_q;

   // R6
   act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd_i |=> $stable(act_q));

   // R7
   auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (icp_vld_i == '0) |=> $stable(auto_q));

endmodule

// File: rtl/rli_cell_accum.sv
module rli_cell_accum #(
   parameter int NUM_LINKS = 4,
   parameter int LINK_W    = 2,
   parameter int CNT_W     = 16,
   parameter bit SATURATE  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINKS-1:0] cell_arr_i,
   input  logic [LINK_W-1:0]    act_ref_i,
   input  logic                 bnd_i,
   output logic [CNT_W-1:0]     rate_o,
   output logic                 done_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_cw
      $error("rli_cell_accum: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] acc_q;
   logic [CNT_W-1:0] rate_q;
   logic             done_q;
   logic             inc;
   logic [CNT_W-1:0] sum;

   assign inc = cell_arr_i[act_ref_i];

   if (SATURATE) begin : g_sat
      assign sum = (acc_q == CNT_MAX) ? CNT_MAX : acc_q + CNT_W'(inc);

      // R5
      acc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!bnd_i && acc_q == CNT_MAX) |=> (acc_q == CNT_MAX));
   end else begin : g_wrap
      assign sum = acc_q + CNT_W'(inc);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         rate_q <= '0;
         done_q <= 1'b0;
      end else if (bnd_i) begin
         acc_q  <= '0;
         rate_q <= sum;
         done_q <= 1'b1;
      end else begin
         acc_q  <= sum;
         done_q <= 1'b0;
      end
   end

   assign rate_o = rate_q;
   assign done_o = done_q;

   // R4
   rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd_i |=> ($stable(rate_q) && !done_q));

   // R3
   latch_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bnd_i |=> (done_q && acc_q == '0));

endmodule

// File: rtl/ref_rate_integrator.sv
module ref_rate_integrator #(
   parameter int NUM_LINKS  = 4,
   parameter int NUM_GROUPS = 2,
   parameter int CNT_W      = 16,
   parameter int PERIOD_W   = 20,
   parameter int AUTO_BIT   = 4,
   parameter bit SATURATE   = 1'b1,
   parameter int LINK_W     = rli_pkg::idx_w(NUM_LINKS),
   parameter int GRP_W      = rli_pkg::idx_w(NUM_GROUPS),
   parameter int CTL_W      = AUTO_BIT + 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           tick_i,
   input  logic [NUM_LINKS-1:0]           cell_arr_i,
   input  logic [NUM_LINKS-1:0]           icp_vld_i,
   input  logic [NUM_LINKS*LINK_W-1:0]    icp_ref_i,
   input  logic [NUM_LINKS*GRP_W-1:0]     link_grp_i,
   input  logic [NUM_GROUPS*CTL_W-1:0]    ref_ctl_i,
   input  logic [NUM_GROUPS*PERIOD_W-1:0] period_i,
   output logic [NUM_GROUPS*CNT_W-1:0]    rate_o,
   output logic [NUM_GROUPS-1:0]          done_o
);
   if (NUM_LINKS < 2 || (NUM_LINKS & (NUM_LINKS - 1)) != 0) begin : g_bad_nl
      $error("ref_rate_integrator: NUM_LINKS must be a power of two, at least 2");
   end
   if (NUM_GROUPS < 1 || NUM_GROUPS > NUM_LINKS) begin : g_bad_ng
      $error("ref_rate_integrator: NUM_GROUPS must be between 1 and NUM_LINKS");
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic              bnd;
      logic [LINK_W-1:0] act_ref;

      rli_tick_timer #(
         .PERIOD_W (PERIOD_W)
      ) u_timer (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick_i   (tick_i),
         .period_i (period_i[g*PERIOD_W +: PERIOD_W]),
         .bnd_o    (bnd)
      );

      rli_ref_track #(
         .NUM_LINKS (NUM_LINKS),
         .LINK_W    (LINK_W),
         .GRP_W     (GRP_W),
         .CTL_W     (CTL_W),
         .AUTO_BIT  (AUTO_BIT),
         .GRP_ID    (g)
      ) u_ref (
         .clk        (clk),
         .rst_n      (rst_n),
         .icp_vld_i  (icp_vld_i),
         .icp_ref_i  (icp_ref_i),
         .link_grp_i (link_grp_i),
         .ctl_i      (ref_ctl_i[g*CTL_W +: CTL_W]),
         .bnd_i      (bnd),
         .act_ref_o  (act_ref)
      );

      rli_cell_accum #(
         .NUM_LINKS (NUM_LINKS),
         .LINK_W    (LINK_W),
         .CNT_W     (CNT_W),
         .SATURATE  (SATURATE)
      ) u_acc (
         .clk        (clk),
         .rst_n      (rst_n),
         .cell_arr_i (cell_arr_i),
         .act_ref_i  (act_ref),
         .bnd_i      (bnd),
         .rate_o     (rate_o[g*CNT_W +: CNT_W]),
         .done_o     (done_o[g])
      );
   end

endmodule

// File: tb/ref_rate_integrator_bench.sv
module ref_rate_integrator_bench;
   localparam int NL = 4;
   localparam int NG = 2;
   localparam int CW = 16;
   localparam int PW = 20;
   localparam int MAXC = 65535;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_i = 1'b0;
   logic [NL-1:0] cell_arr_i = '0;
   logic [NL-1:0] icp_vld_i = '0;
   logic [2*NL-1:0] icp_ref_i = '0;
   logic [NL-1:0] link_grp_i = 4'b1100;
   logic [5*NG-1:0] ref_ctl_i = '0;
   logic [PW*NG-1:0] period_i = '0;
   logic [CW*NG-1:0] rate_o;
   logic [NG-1:0] done_o;

   ref_rate_integrator u_ref_rate_integrator (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cell_arr_i(cell_arr_i),
      .icp_vld_i(icp_vld_i), .icp_ref_i(icp_ref_i), .link_grp_i(link_grp_i),
      .ref_ctl_i(ref_ctl_i), .period_i(period_i), .rate_o(rate_o), .done_o(done_o)
   );

   always #4 clk = ~clk;  // 125 MHz

   int n_chk = 0;
   int n_bad = 0;
   string cur_req = "R1";

   // stimulus knobs (percent)
   int p_tick = 100;
   int p_cell = 50;
   int p_icp  = 0;

   // behavioural model state
   int m_tcnt[NG];
   int m_acc[NG];
   int m_rate[NG];
   int m_done[NG];
   int m_act[NG];
   int m_auto[NG];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int g = 0; g < NG; g++) begin
            m_tcnt[g] = 0; m_acc[g] = 0; m_rate[g] = 0;
            m_done[g] = 0; m_act[g] = 0; m_auto[g] = 0;
         end
      end else begin
         for (int g = 0; g < NG; g++) begin
            int per, sum, nref;
            bit bnd;
            per = int'(period_i[g*PW +: PW]);
            if (per == 0) per = 1;
            bnd = tick_i && (m_tcnt[g] + 1 >= per);
            sum = m_acc[g] + int'(cell_arr_i[m_act[g]]);
            if (sum > MAXC) sum = MAXC;
            nref = ref_ctl_i[g*5 + 4] ? m_auto[g] : int'(ref_ctl_i[g*5 +: 2]);
            if (bnd) begin
               m_rate[g] = sum; m_acc[g] = 0; m_tcnt[g] = 0;
               m_act[g] = nref; m_done[g] = 1;
            end else begin
               m_acc[g] = sum; m_done[g] = 0;
               if (tick_i) m_tcnt[g] = m_tcnt[g] + 1;
            end
            for (int l = 0; l < NL; l++) begin
               if (icp_vld_i[l] && int'(link_grp_i[l]) == g) begin
                  m_auto[g] = int'(icp_ref_i[2*l +: 2]);
                  break;
               end
            end
         end
      end
   end

   task automatic compare();
      for (int g = 0; g < NG; g++) begin
         n_chk++;
         if (int'(rate_o[g*CW +: CW]) != m_rate[g]) begin
            n_bad++;
            $display("FAIL %s group %0d rate actual %0d expected %0d",
                     cur_req, g, rate_o[g*CW +: CW], m_rate[g]);
         end
         n_chk++;
         if (int'(done_o[g]) != m_done[g]) begin
            n_bad++;
            $display("FAIL %s group %0d done actual %0d expected %0d",
                     cur_req, g, done_o[g], m_done[g]);
         end
      end
   endtask

   task automatic drive();
      tick_i = ($urandom_range(99) < p_tick);
      for (int l = 0; l < NL; l++) begin
         cell_arr_i[l] = ($urandom_range(99) < p_cell);
         icp_vld_i[l]  = ($urandom_range(99) < p_icp);
         icp_ref_i[2*l +: 2] = 2'($urandom_range(3));
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare();
         drive();
      end
   endtask

   task automatic set_ctl(input int g, input bit auto_on, input int link);
      ref_ctl_i[g*5 +: 5] = {auto_on, 2'b00, 2'(link)};
   endtask

   // watchdog
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd >= 200000) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      period_i[0 +: PW]  = PW'(5);
      period_i[PW +: PW] = PW'(7);
      set_ctl(0, 1'b0, 1);
      set_ctl(1, 1'b0, 3);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state visible on outputs
      cur_req = "R1";
      compare();
      rst_n = 1'b1;
      // R1: first window counts on link 0 although link 1 / 3 is selected
      run(8);
      // R3: dense ticks, random arrivals, fixed manual references
      cur_req = "R3";
      run(300);
      // R4: done strobe and hold between boundaries
      cur_req = "R4";
      p_cell = 80;
      run(200);
      // R9: only the active link counts
      cur_req = "R9";
      p_cell = 30;
      run(200);
      // R2: sparse irregular ticks and a zero period
      cur_req = "R2";
      p_tick = 30;
      run(400);
      period_i[0 +: PW] = '0;
      period_i[PW +: PW] = PW'(1);
      p_tick = 60;
      run(200);
      // R6: manual changes in mid window
      cur_req = "R6";
      period_i[0 +: PW] = PW'(9);
      period_i[PW +: PW] = PW'(4);
      p_tick = 100;
      for (int k = 0; k < 60; k++) begin
         set_ctl(0, 1'b0, k % 4);
         set_ctl(1, 1'b0, (k * 3) % 4);
         run(7);
      end
      // R7: control cells, simultaneous and foreign-group strobes
      cur_req = "R7";
      set_ctl(0, 1'b1, 0);
      set_ctl(1, 1'b1, 0);
      p_icp = 20;
      run(600);
      link_grp_i = 4'b0101;
      run(400);
      // R8: dense control cells so some land in boundary cycles
      cur_req = "R8";
      p_icp = 60;
      period_i[0 +: PW] = PW'(2);
      period_i[PW +: PW] = PW'(3);
      run(600);
      // R5: long window with arrivals every cycle
      cur_req = "R5";
      p_icp = 0;
      set_ctl(0, 1'b0, 0);
      set_ctl(1, 1'b0, 2);
      period_i[0 +: PW] = PW'(70000);
      period_i[PW +: PW] = PW'(70000);
      p_cell = 100;
      p_tick = 100;
      run(70010);
      n_chk++;
      if (int'(rate_o[0 +: CW]) != MAXC) begin
         n_bad++;
         $display("FAIL R5 saturated rate actual %0d expected %0d", rate_o[0 +: CW], MAXC);
      end
      run(20);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule